// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the pin-facing half of a serial memory slave. It oversamples chip select, serial clock, data in and an active-low pause pin with a fast system clock. Received bits are assembled into bytes MSB first on rising serial clock edges, and a one-cycle strobe marks each complete byte. Transmit bytes are shifted out MSB first and advance on falling serial clock edges. The bus idles with the serial clock low.

A pause (hold) condition lets the bus master suspend a transfer without deselecting the slave. During a pause the output is released, clock and data are ignored, and the bit position and both shift registers keep their values, so the transfer picks up exactly where it stopped. Both entry into and exit from the pause only take effect while the serial clock is low. An edge of the pause pin seen while the clock is high is deferred to the next clock-low.

Deselecting the slave during a pause emits a one-cycle logic-reset pulse. The slave then stays inert until the pause pin has been released with the slave deselected. Internal write, program and erase timers live elsewhere and are not touched by the pause.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data in is shifted into the receive register MSB first on each rising serial clock edge while active. After the eighth bit, `rx_byte_o` holds the byte and `rx_valid_o` is high for exactly one system clock cycle.
- R2: The transmit byte is captured from `tx_byte_i` continuously while deselected. Its MSB drives `miso_o` once the slave is selected, and each falling edge advances to the next bit. The falling edge that follows the eighth rising edge of a byte loads a fresh `tx_byte_i` (multi-byte transfers).
- R3: `miso_oe_o` is 1 only while the slave is selected and not paused; it is 0 out of reset and while deselected.
- R4: A falling edge of the pause pin, seen while selected with the serial clock low, starts the pause at once. `miso_oe_o` drops to 0, and clock edges give no strobes and no bit progress.
- R5: If the pause pin falls while the serial clock is high, the slave stays active (`miso_oe_o` stays 1) until the clock next falls. That falling edge still advances the output, and the pause then begins.
- R6: A rising pause pin with the clock low ends the pause at once. With the clock high, the pause lasts until the clock next falls, and that falling edge is ignored.
- R7: Bit count and both shift registers keep their values during a pause. A byte split by a pause is received and transmitted intact.
- R8: Chip select going high during a pause produces a one-cycle `logic_rst_o` pulse and clears the bit position. The next transfer starts at bit 7.
- R9: After the reset of R8, selecting the slave again while the pause pin is still low has no effect: `miso_oe_o` stays 0 and no byte strobes occur. Normal operation returns only once the pause pin is high with the slave deselected, followed by a new selection.
- R10: A falling pause pin while deselected does not start a pause. A later selection with the pin still low gives normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select pin level, active low |
| sck_i | input | 1 | Serial clock pin level, idles low |
| mosi_i | input | 1 | Serial data in pin level |
| hold_ni | input | 1 | Pause pin level, active low |
| tx_byte_i | input | DATA_W | Next byte to transmit |
| rx_byte_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| logic_rst_o | output | 1 | One-cycle pulse on deselect during pause |

## Verification
Every pin passes two synchronizer flops and one state register, so a pin change shows up on `miso_oe_o`, `miso_o`, `rx_valid_o` and `logic_rst_o` in the third system clock after it. The bench holds every pin level for four system clocks and samples one nanosecond after an edge, always at the end of such a hold. Each check therefore reads a settled result. Byte strobes and reset pulses last one cycle, so a monitor counts them at every edge, and the checks compare counts and the latched byte rather than sampling the strobe directly.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [2:0] {
    HS_RUN        = 3'd0,
    HS_ENTER_WAIT = 3'd1,
    HS_HOLD       = 3'd2,
    HS_EXIT_WAIT  = 3'd3,
    HS_LOCK       = 3'd4
  } hold_state_e;

  // synchronizer lanes
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_MOSI = 2;
  localparam int PIN_HOLD = 3;
  localparam int NUM_PINS = 4;

  // idle pin levels: deselected, pause released
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1001;

  // edge detector lanes
  localparam int EDG_SCK  = 0;
  localparam int EDG_HOLD = 1;
  localparam int NUM_EDG  = 2;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] pins_o
);

  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= pins_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign pins_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
    assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_act_i,
  input  logic        sck_lvl_i,
  input  logic        hold_lvl_i,   // 1 = released
  input  logic        hold_fall_i,
  input  logic        hold_rise_i,
  output hold_state_e state_o,
  output logic        shift_en_o,
  output logic        drive_en_o,
  output logic        logic_rst_o
);

  hold_state_e state_q, state_d;
  logic        lrst_q;
  logic        paused;

  assign paused = (state_q == HS_HOLD) || (state_q == HS_EXIT_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_RUN: begin
        if (cs_act_i && hold_fall_i) state_d = sck_lvl_i ? HS_ENTER_WAIT : HS_HOLD;
      end
      HS_ENTER_WAIT: begin
        if (!cs_act_i || hold_rise_i) state_d = HS_RUN;
        else if (!sck_lvl_i)          state_d = HS_HOLD;
      end
      HS_HOLD: begin
        if (!cs_act_i)       state_d = HS_LOCK;
        else if (hold_lvl_i) state_d = sck_lvl_i ? HS_EXIT_WAIT : HS_RUN;
      end
      HS_EXIT_WAIT: begin
        if (!cs_act_i)        state_d = HS_LOCK;
        else if (!hold_lvl_i) state_d = HS_HOLD;
        else if (!sck_lvl_i)  state_d = HS_RUN;
      end
      HS_LOCK: begin
        if (!cs_act_i && hold_lvl_i) state_d = HS_RUN;
      end
      default: state_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_RUN;
      lrst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lrst_q  <= paused && !cs_act_i;
    end
  end

  // the clock edge that completes a deferred entry is still honoured
  assign shift_en_o  = (state_q == HS_RUN) || (state_q == HS_ENTER_WAIT);
  assign drive_en_o  = cs_act_i && shift_en_o;
  assign state_o     = state_q;
  assign logic_rst_o = lrst_q;

endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              shift_en_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              miso_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [DATA_W-1:0] rx_sh_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sh_q, tx_sh_q, rx_byte_q;
  logic              valid_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sh_q[DATA_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rx_byte_q <= '0;
      valid_q   <= 1'b0;
    end else if (!sel_i) begin
      cnt_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= tx_byte_i;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (shift_en_i && sck_rise_i) begin
        rx_sh_q <= rx_next;
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          rx_byte_q <= rx_next;
          valid_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (shift_en_i && sck_fall_i) begin
        if (cnt_q == '0) tx_sh_q <= tx_byte_i;
        else             tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = valid_q;
  assign miso_o     = tx_sh_q[DATA_W-1];
  assign bit_cnt_o  = cnt_q;
  assign rx_sh_o    = rx_sh_q;

endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              logic_rst_o
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [NUM_PINS-1:0] pins_raw, pins_s;
  logic [NUM_EDG-1:0]  edg_lvl, edg_rise, edg_fall;
  logic                cs_act, sck_rise, sck_fall;
  logic                shift_en, drive_en;
  hold_state_e         state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [DATA_W-1:0]   rx_sh;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_ni;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_MOSI] = mosi_i;
    pins_raw[PIN_HOLD] = hold_ni;
  end

  spi_hold_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_raw),
    .pins_o (pins_s)
  );

  always_comb begin
    edg_lvl           = '0;
    edg_lvl[EDG_SCK]  = pins_s[PIN_SCK];
    edg_lvl[EDG_HOLD] = pins_s[PIN_HOLD];
  end

  spi_hold_edge #(.N(NUM_EDG), .RST_VAL(2'b10)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (edg_lvl),
    .rise_o (edg_rise),
    .fall_o (edg_fall)
  );

  assign cs_act   = ~pins_s[PIN_CS];
  assign sck_rise = edg_rise[EDG_SCK];
  assign sck_fall = edg_fall[EDG_SCK];

  spi_hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .sck_lvl_i   (pins_s[PIN_SCK]),
    .hold_lvl_i  (pins_s[PIN_HOLD]),
    .hold_fall_i (edg_fall[EDG_HOLD]),
    .hold_rise_i (edg_rise[EDG_HOLD]),
    .state_o     (state),
    .shift_en_o  (shift_en),
    .drive_en_o  (drive_en),
    .logic_rst_o (logic_rst_o)
  );

  spi_hold_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (cs_act && (state != HS_LOCK)),
    .shift_en_i (shift_en),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .mosi_i     (pins_s[PIN_MOSI]),
    .tx_byte_i  (tx_byte_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .miso_o     (miso_o),
    .bit_cnt_o  (bit_cnt),
    .rx_sh_o    (rx_sh)
  );

  assign miso_oe_o = drive_en;

endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act,
  input logic              sck_rise,
  input hold_state_e       state,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] rx_sh,
  input logic              rx_valid_o,
  input logic              miso_oe_o,
  input logic              logic_rst_o
);

  assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_valid_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sck_rise) && ($past(bit_cnt) == CNT_W'(DATA_W - 1)));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == HS_HOLD && cs_act) |=> $stable(bit_cnt) && $stable(rx_sh));

  assert_deselect_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == HS_HOLD || state == HS_EXIT_WAIT) && !cs_act) |=> logic_rst_o && state == HS_LOCK);

  assert_rst_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |=> !logic_rst_o);

  assert_lock_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == HS_LOCK) |-> !miso_oe_o && !rx_valid_o);

endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_act      (cs_act),
  .sck_rise    (sck_rise),
  .state       (state),
  .bit_cnt     (bit_cnt),
  .rx_sh       (rx_sh),
  .rx_valid_o  (rx_valid_o),
  .miso_oe_o   (miso_oe_o),
  .logic_rst_o (logic_rst_o)
);

// File: tb/tb_spi_hold_frontend.sv
`timescale 1ns/1ps
module tb_spi_hold_frontend;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       rx_valid, miso, miso_oe, logic_rst;

  int n_chk = 0, n_fail = 0, n_valid = 0, n_lrst = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  // rx, tx pairs walked by the vector loop
  localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h8001, 16'h5AA5, 16'h6B94};

  always #2 clk = ~clk;

  spi_hold_frontend dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_n), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .miso_o(miso), .miso_oe_o(miso_oe), .logic_rst_o(logic_rst)
  );

  always @(posedge clk) begin
    if (rx_valid) begin n_valid++; last_rx = rx_byte; end
    if (logic_rst) n_lrst++;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic m);
    mosi = b; tick(4);
    m = miso;
    sck = 1'b1; tick(4);
    sck = 1'b0;
  endtask

  task automatic bits(input logic [7:0] mo, input int hi, input int lo, inout logic [7:0] mi);
    for (int i = hi; i >= lo; i--) begin
      logic m;
      bit_io(mo[i], m);
      mi[i] = m;
    end
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    mi = 8'h00;
    bits(mo, 7, 0, mi);
    tick(4);
  endtask

  task automatic select;   cs_n = 1'b0; tick(4); endtask
  task automatic deselect; sck = 1'b0; cs_n = 1'b1; tick(4); endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] mi, mi2;
    int v0, l0;
    tick(3);
    check("R3 reset oe", miso_oe, 0);
    check("R1 reset valid", rx_valid, 0);
    check("R8 reset lrst", logic_rst, 0);
    rst_n = 1'b1; tick(4);
    check("R3 idle oe", miso_oe, 0);

    // vector loop: R1 receive, R2 transmit
    for (int k = 0; k < 6; k++) begin
      tx_byte = VEC[k][7:0]; tick(4);
      v0 = n_valid;
      select();
      check("R3 selected oe", miso_oe, 1);
      xfer(VEC[k][15:8], mi);
      check("R1 rx byte", last_rx, VEC[k][15:8]);
      check("R1 one strobe", n_valid, v0 + 1);
      check("R2 tx byte", mi, VEC[k][7:0]);
      deselect();
      check("R3 deselected oe", miso_oe, 0);
    end

    // R2 two bytes in one selection
    tx_byte = 8'h81; tick(4);
    v0 = n_valid;
    select();
    tx_byte = 8'h7E;
    xfer(8'h11, mi);
    xfer(8'h22, mi2);
    check("R2 first byte", mi, 8'h81);
    check("R2 second byte", mi2, 8'h7E);
    check("R1 second rx", last_rx, 8'h22);
    check("R1 two strobes", n_valid, v0 + 2);
    deselect();

    // R4 / R7 pause with clock low
    tx_byte = 8'hC3; tick(4);
    v0 = n_valid; mi = 8'h00;
    select();
    bits(8'h6E, 7, 5, mi);
    tick(4);
    hold_n = 1'b0; tick(4);
    check("R4 oe off in pause", miso_oe, 0);
    for (int j = 0; j < 3; j++) begin
      mosi = j[0]; sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
    check("R4 no strobe in pause", n_valid, v0);
    hold_n = 1'b1; tick(4);
    check("R6 immediate exit oe", miso_oe, 1);
    bits(8'h6E, 4, 0, mi);
    tick(4);
    check("R7 rx across pause", last_rx, 8'h6E);
    check("R7 tx across pause", mi, 8'hC3);
    check("R7 one strobe", n_valid, v0 + 1);
    deselect();

    // R5 / R6 deferred entry and exit
    tx_byte = 8'h5A; tick(4);
    mi = 8'h00;
    select();
    bits(8'h93, 7, 4, mi);
    mosi = 1'b0; tick(4);
    mi[3] = miso;
    sck = 1'b1; tick(4);
    hold_n = 1'b0; tick(4);
    check("R5 still active while clock high", miso_oe, 1);
    sck = 1'b0; tick(4);
    check("R5 pause after clock low", miso_oe, 0);
    sck = 1'b1; tick(4);
    hold_n = 1'b1; tick(4);
    check("R6 exit deferred", miso_oe, 0);
    sck = 1'b0; tick(4);
    check("R6 exit at clock low", miso_oe, 1);
    bits(8'h93, 2, 0, mi);
    tick(4);
    check("R5 rx intact", last_rx, 8'h93);
    check("R5 tx intact", mi, 8'h5A);
    deselect();

    // R8 / R9 deselect during pause, lockout
    tx_byte = 8'h00; tick(4);
    l0 = n_lrst; mi = 8'h00;
    select();
    bits(8'hFF, 7, 5, mi);
    tick(4);
    hold_n = 1'b0; tick(4);
    cs_n = 1'b1; tick(4);
    check("R8 reset pulse", n_lrst, l0 + 1);
    check("R8 oe off", miso_oe, 0);
    cs_n = 1'b0; tick(4);
    check("R9 locked oe", miso_oe, 0);
    v0 = n_valid;
    xfer(8'hA7, mi);
    check("R9 no strobes locked", n_valid, v0);
    check("R9 oe still off", miso_oe, 0);
    cs_n = 1'b1; tick(4);
    hold_n = 1'b1; tick(4);
    tx_byte = 8'hE1; tick(4);
    select();
    check("R9 oe restored", miso_oe, 1);
    xfer(8'h47, mi);
    check("R8 rx from bit 7", last_rx, 8'h47);
    check("R8 tx from bit 7", mi, 8'hE1);
    check("R8 single pulse", n_lrst, l0 + 1);
    deselect();

    // R10 pause pin falls while deselected
    tx_byte = 8'h3C;
    hold_n = 1'b0; tick(4);
    select();
    check("R10 oe on", miso_oe, 1);
    xfer(8'h2D, mi);
    check("R10 rx", last_rx, 8'h2D);
    check("R10 tx", mi, 8'h3C);
    deselect();
    hold_n = 1'b1; tick(4);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule